// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full logic. One offset sets the almost-empty threshold and the other sets the almost-full threshold. Both offsets are 11 bits wide, which covers a 2048-deep FIFO. The block drives both values out continuously, so the flag logic next to it can compare them against the fill level. Generating the flags is not part of this block.

Master reset samples a single active-low strobe, `ld_n`, and that one sample settles two things. The first is the default value of both offsets: 127 words or 1023 words. The second is how software may reload them: through a parallel bus or through a one-bit serial input. The chosen loading method stays fixed until the next master reset. The other method is ignored.

Read-back always uses the parallel bus. Whenever `ld_n` is high, access restarts from the almost-empty offset, so each new low period of `ld_n` begins a fresh load or read sequence.

Top module: `flag_offset_loader`

## Requirements
- R1: In a cycle with `rst` high and `ld_n` low, both offsets become 127 and the parallel loading method is selected.
- R2: In a cycle with `rst` high and `ld_n` high, both offsets become 1023 and the serial loading method is selected.
- R3: In parallel mode, each clock edge with `ld_n` and `wen_n` both low writes `wdata` into the offset selected by an internal pointer. The pointer visits the almost-empty offset first and then the almost-full offset. A third write wraps around to the almost-empty offset.
- R4: While `ld_n` is high, neither offset changes, and the pointer and the serial bit position return to the almost-empty offset and bit 0.
- R5: In either mode, an edge with `ld_n` and `ren_n` both low loads `rdata` with the offset at the pointer and then advances the pointer in the same order as writes. `rdata` is 0 after reset and otherwise holds its value. When `wen_n` and `ren_n` are both low in parallel mode, only the write takes place.
- R6: In serial mode, each edge with `ld_n` and `sen_n` both low stores `ser_in` at the next chain position. Positions 0 to 10 are bits 0 to 10 of the almost-empty offset. Positions 11 to 21 are bits 0 to 10 of the almost-full offset. Bits that arrive after all 22 positions are filled are ignored.
- R7: In serial mode, edges with `sen_n` high leave both offsets unchanged.
- R8: The method not selected at reset has no effect. `wen_n` writes are ignored in serial mode, and `sen_n`/`ser_in` are ignored in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous master reset, active high |
| ld_n | input | 1 | Load strobe, active low; sampled at reset to choose defaults and method |
| sen_n | input | 1 | Serial shift enable, active low |
| ser_in | input | 1 | Serial data bit |
| wen_n | input | 1 | Parallel write enable, active low |
| ren_n | input | 1 | Parallel read-back enable, active low |
| wdata | input | 11 | Parallel write data |
| rdata | output | 11 | Registered read-back data |
| ae_offset | output | 11 | Almost-empty threshold offset |
| af_offset | output | 11 | Almost-full threshold offset |

## Verification
The parallel path is swept with sixteen arithmetically spread value pairs, which separates the two offsets and exposes any swap or merge of their storage. Writes of three values check the wrap-around, and a write after `ld_n` goes high checks that the pointer restarts. The serial path is swept with another sixteen pairs, fed least significant bit first, with surplus one-bits appended to show that the chain stops after 22 positions. A half-length load checks that the serial position restarts. Each mode is also driven with the other mode's controls and with `sen_n` high, so that a leaking load path changes a visible offset. Read-back is tried in both modes, with `ld_n` high, and with a write and a read requested together.

// File: rtl/fol_pkg.sv
package fol_pkg;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e sel_advance(input ofs_sel_e s);
        return (s == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

    function automatic int chain_bits(input int w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/fol_seq.sv
module fol_seq
    import fol_pkg::*;
#(
    parameter int OFS_W = 11,
    localparam int CHAIN_LEN = chain_bits(OFS_W),
    localparam int CNT_W = $clog2(CHAIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             wen_n,
    input  logic             ren_n,
    output load_mode_e       mode,
    output ofs_sel_e         sel,
    output logic             par_wr,
    output logic             rd_en,
    output logic             ser_wr,
    output logic [CNT_W-1:0] ser_idx
);

    logic access;

    always_comb begin
        access = !rst && !ld_n;
        par_wr = access && (mode == LOAD_PAR) && !wen_n;
        rd_en  = access && !par_wr && !ren_n;
        ser_wr = access && (mode == LOAD_SER) && !sen_n
                 && (ser_idx < CNT_W'(CHAIN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= ld_n ? LOAD_SER : LOAD_PAR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ld_n) begin
            sel <= SEL_AE;
        end else if (par_wr || rd_en) begin
            sel <= sel_advance(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ld_n) begin
            ser_idx <= '0;
        end else if (ser_wr) begin
            ser_idx <= ser_idx + 1'b1;
        end
    end

endmodule

// File: rtl/fol_regs.sv
module fol_regs
    import fol_pkg::*;
#(
    parameter int OFS_W    = 11,
    parameter int DEF_NEAR = 127,
    parameter int DEF_FAR  = 1023,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n,
    input  ofs_sel_e         sel,
    input  logic             par_wr,
    input  logic             rd_en,
    input  logic             ser_wr,
    input  logic [CNT_W-1:0] ser_idx,
    input  logic             ser_in,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] rdata,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);

    localparam logic [OFS_W-1:0] NEAR_V = OFS_W'(DEF_NEAR);
    localparam logic [OFS_W-1:0] FAR_V  = OFS_W'(DEF_FAR);

    for (genvar k = 0; k < 2; k++) begin : g_ofs
        localparam ofs_sel_e MY_SEL = (k == 0) ? SEL_AE : SEL_AF;
        localparam int BASE = k * OFS_W;
        logic [OFS_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= ld_n ? FAR_V : NEAR_V;
            end else if (par_wr && (sel == MY_SEL)) begin
                q <= wdata;
            end else if (ser_wr) begin
                for (int b = 0; b < OFS_W; b++) begin
                    if (ser_idx == CNT_W'(BASE + b)) begin
                        q[b] <= ser_in;
                    end
                end
            end
        end
    end

    assign ae_q = g_ofs[0].q;
    assign af_q = g_ofs[1].q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= (sel == SEL_AF) ? af_q : ae_q;
        end
    end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import fol_pkg::*;
#(
    parameter int OFS_W    = 11,
    parameter int DEF_NEAR = 127,
    parameter int DEF_FAR  = 1023
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             ser_in,
    input  logic             wen_n,
    input  logic             ren_n,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] rdata,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset
);

    localparam int CHAIN_LEN = chain_bits(OFS_W);
    localparam int CNT_W     = $clog2(CHAIN_LEN + 1);

    load_mode_e       mode;
    ofs_sel_e         sel;
    logic             par_wr;
    logic             rd_en;
    logic             ser_wr;
    logic [CNT_W-1:0] ser_idx;

    fol_seq #(.OFS_W(OFS_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .ld_n   (ld_n),
        .sen_n  (sen_n),
        .wen_n  (wen_n),
        .ren_n  (ren_n),
        .mode   (mode),
        .sel    (sel),
        .par_wr (par_wr),
        .rd_en  (rd_en),
        .ser_wr (ser_wr),
        .ser_idx(ser_idx)
    );

    fol_regs #(
        .OFS_W   (OFS_W),
        .DEF_NEAR(DEF_NEAR),
        .DEF_FAR (DEF_FAR),
        .CNT_W   (CNT_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .ld_n   (ld_n),
        .sel    (sel),
        .par_wr (par_wr),
        .rd_en  (rd_en),
        .ser_wr (ser_wr),
        .ser_idx(ser_idx),
        .ser_in (ser_in),
        .wdata  (wdata),
        .rdata  (rdata),
        .ae_q   (ae_offset),
        .af_q   (af_offset)
    );

endmodule

// File: rtl/fol_chk.sv
module fol_chk
    import fol_pkg::*;
#(
    parameter int OFS_W    = 11,
    parameter int DEF_NEAR = 127,
    parameter int DEF_FAR  = 1023
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_n,
    input logic             sen_n,
    input logic             wen_n,
    input logic             ren_n,
    input load_mode_e       mode,
    input ofs_sel_e         sel,
    input logic [OFS_W-1:0] rdata,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset
);

    // R1
    near_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(ld_n)) |->
        (ae_offset == OFS_W'(DEF_NEAR) && af_offset == OFS_W'(DEF_NEAR) && mode == LOAD_PAR));

    // R2
    far_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && $past(ld_n)) |->
        (ae_offset == OFS_W'(DEF_FAR) && af_offset == OFS_W'(DEF_FAR) && mode == LOAD_SER));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> ($stable(ae_offset) && $stable(af_offset)));

    // R4
    ptr_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ld_n |=> (sel == SEL_AE));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_n || ren_n) |=> $stable(rdata));

    // R7
    serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LOAD_SER && sen_n) |=> ($stable(ae_offset) && $stable(af_offset)));

    // R8
    parallel_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LOAD_PAR && wen_n) |=> ($stable(ae_offset) && $stable(af_offset)));

endmodule

bind flag_offset_loader fol_chk #(
    .OFS_W   (OFS_W),
    .DEF_NEAR(DEF_NEAR),
    .DEF_FAR (DEF_FAR)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_n     (ld_n),
    .sen_n    (sen_n),
    .wen_n    (wen_n),
    .ren_n    (ren_n),
    .mode     (mode),
    .sel      (sel),
    .rdata    (rdata),
    .ae_offset(ae_offset),
    .af_offset(af_offset)
);

// File: tb/flag_offset_loader_test.sv
`timescale 1ns/1ps
module flag_offset_loader_test;

    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_n = 1'b1;
    logic         sen_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         wen_n = 1'b1;
    logic         ren_n = 1'b1;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic [W-1:0] ae_offset;
    logic [W-1:0] af_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    flag_offset_loader uut (
        .clk      (clk),
        .rst      (rst),
        .ld_n     (ld_n),
        .sen_n    (sen_n),
        .ser_in   (ser_in),
        .wen_n    (wen_n),
        .ren_n    (ren_n),
        .wdata    (wdata),
        .rdata    (rdata),
        .ae_offset(ae_offset),
        .af_offset(af_offset)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, advance across one rising edge
    task automatic step(input logic l, input logic s, input logic si,
                        input logic w, input logic r, input int d);
        ld_n = l; sen_n = s; ser_in = si; wen_n = w; ren_n = r; wdata = W'(d);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 0);
    endtask

    task automatic do_reset(input logic l);
        rst = 1'b1;
        step(l, 1'b1, 1'b0, 1'b1, 1'b1, 0);
        rst = 1'b0;
        idle();
    endtask

    task automatic pwrite(input int d);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, d);
    endtask

    task automatic pread();
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    endtask

    task automatic sfeed(input int v, input int nbits);
        for (int b = 0; b < nbits; b++) begin
            step(1'b0, 1'b0, v[b], 1'b1, 1'b1, 0);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // ---------------- parallel configuration ----------------
        do_reset(1'b0);
        chk("R1 ae default", int'(ae_offset), 127);
        chk("R1 af default", int'(af_offset), 127);
        chk("R5 rdata reset", int'(rdata), 0);

        // R8: serial controls ignored in parallel mode
        for (int b = 0; b < 2 * W + 2; b++) step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 0);
        idle();
        chk("R8 par ae untouched", int'(ae_offset), 127);
        chk("R8 par af untouched", int'(af_offset), 127);

        for (int i = 0; i < 16; i++) begin
            int a, c;
            a = (i * 137 + 5) % 2048;
            c = (i * 411 + 1000) % 2048;
            pwrite(a); pwrite(c); idle();
            chk("R3 ae write", int'(ae_offset), a);
            chk("R3 af write", int'(af_offset), c);
            pread();
            chk("R5 read ae", int'(rdata), a);
            pread();
            chk("R5 read af", int'(rdata), c);
            pread();
            chk("R5 read wrap", int'(rdata), a);
            // R4: ld_n high, a write request is ignored
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12);
            chk("R4 idle ae", int'(ae_offset), a);
            chk("R4 idle af", int'(af_offset), c);
            chk("R5 rdata hold", int'(rdata), a);
        end

        // R3 wrap of write pointer
        pwrite(11); pwrite(22); pwrite(33); idle();
        chk("R3 wrap ae", int'(ae_offset), 33);
        chk("R3 wrap af", int'(af_offset), 22);

        // R4 pointer restart
        pwrite(44); idle(); pwrite(55); idle();
        chk("R4 restart ae", int'(ae_offset), 55);
        chk("R4 restart af", int'(af_offset), 22);

        // R5 write wins over read, pointer advances once
        pread(); pread(); idle();             // rdata = 22 (af)
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 66);
        chk("R5 both: ae written", int'(ae_offset), 66);
        chk("R5 both: rdata held", int'(rdata), 22);
        pread();
        chk("R5 both: next read af", int'(rdata), 22);
        idle();

        // ---------------- serial configuration ----------------
        do_reset(1'b1);
        chk("R2 ae default", int'(ae_offset), 1023);
        chk("R2 af default", int'(af_offset), 1023);

        // R8: parallel writes ignored in serial mode
        pwrite(5); pwrite(6); idle();
        chk("R8 ser ae untouched", int'(ae_offset), 1023);
        chk("R8 ser af untouched", int'(af_offset), 1023);

        for (int i = 0; i < 16; i++) begin
            int a, c;
            a = (i * 293 + 17) % 2048;
            c = (i * 777 + 3) % 2048;
            sfeed(a, W); sfeed(c, W);
            sfeed(2047, 3);                   // surplus bits
            idle();
            chk("R6 serial ae", int'(ae_offset), a);
            chk("R6 serial af", int'(af_offset), c);
            // R7: sen_n high holds while bits toggle
            for (int b = 0; b < 6; b++) step(1'b0, 1'b1, b[0], 1'b1, 1'b1, 0);
            idle();
            chk("R7 hold ae", int'(ae_offset), a);
            chk("R7 hold af", int'(af_offset), c);
            pread();
            chk("R5 serial read ae", int'(rdata), a);
            pread();
            chk("R5 serial read af", int'(rdata), c);
            idle();
        end

        // R6 restart of the bit position after ld_n high
        begin
            int prev_af;
            prev_af = int'(af_offset);
            sfeed(1365, W); idle();
            chk("R6 restart ae", int'(ae_offset), 1365);
            chk("R6 restart af", int'(af_offset), prev_af);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule